// File: doc/BRIEF.md
# Elementary-Stream Decoder Output Port

This block drains two byte streams, audio and video, from internal first-word-fall-through FIFOs to an external decoder. Both streams share one output bus. The decoder paces each stream on its own active-low request line, so the transfer rate depends only on those two lines. A mode input selects how a byte is sent. In serial mode the byte goes out one bit per clock on bus bit 0. In parallel mode the whole 8-bit bus carries one byte per clock.

Each transfer cycle raises a valid strobe. A stream-select output tells the decoder which stream owns the current byte. The source FIFOs mark each byte with a discontinuity flag. When the flag is set, an active-low error output goes low for the cycles of that byte only. When both streams are ready at a byte boundary, a round-robin arbiter alternates between them. A serial byte is never split between the two streams.

Top module: `es_out_port`

## Requirements
- R1: While reset is held and in the first cycle after it, the valid strobe is low and the active-low error output is high. Neither FIFO is popped while both requests are high.
- R2: A byte of a stream is taken from its FIFO (pop high) only when that stream's request is low, its FIFO reports data, and no serial byte is still in progress. If any of these conditions fails, nothing is popped and no transfer appears.
- R3: In parallel mode (mode input = 1 at the pop cycle), the popped byte appears on bus bits 7..0 in the next cycle with the valid strobe high. This allows one byte per clock.
- R4: In serial mode (mode input = 0 at the pop cycle), the popped byte is shifted out on bus bit 0, most significant bit first. The output uses 8 consecutive cycles starting the cycle after the pop, with valid high and bus bits 7..1 at zero.
- R5: Once a serial byte has started, all 8 bits are sent without a gap, whatever the request lines or the mode input do meanwhile. The next byte waits for its request at the next byte boundary.
- R6: When both streams are eligible at a byte boundary, the stream not granted last wins. The first contested grant after reset goes to audio.
- R7: The stream-select output is 0 for an audio byte and 1 for a video byte. It stays stable for every cycle of that byte.
- R8: The error output is low for exactly the cycles of a byte whose FIFO discontinuity flag was set. It is high at all other times, including whenever valid is low.
- R9: A serial byte may start in the cycle its predecessor's last bit is on the bus. Back-to-back serial bytes therefore show valid high continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; the decoder samples on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| par_mode | input | 1 | 1 = byte-parallel transfers, 0 = bit-serial on bit 0 |
| aud_req_n | input | 1 | Decoder audio request, active low |
| aud_avail | input | 1 | Audio FIFO holds a byte |
| aud_byte | input | DW | Audio FIFO head byte |
| aud_disc | input | 1 | Discontinuity flag of the audio head byte |
| aud_pop | output | 1 | Consume the audio head byte at this edge |
| vid_req_n | input | 1 | Decoder video request, active low |
| vid_avail | input | 1 | Video FIFO holds a byte |
| vid_byte | input | DW | Video FIFO head byte |
| vid_disc | input | 1 | Discontinuity flag of the video head byte |
| vid_pop | output | 1 | Consume the video head byte at this edge |
| dout | output | DW | Shared compressed-data bus to the decoder |
| dvalid | output | 1 | Transfer strobe, active high |
| dstrm | output | 1 | Stream of the current transfer, 0 audio, 1 video |
| derr_n | output | 1 | Discontinuity error, active low, per byte |

## Verification
The bench drives requests that drop in the middle of a serial byte and a mode input that flips mid-byte. A design that stalled the shift or mixed the two modes would leave gaps or stray bits on the bus. Contested grants in both modes expose an arbiter that starves one stream or picks video first after reset. Discontinuity-flagged bytes next to clean ones catch an error output that lasts too long, covers only the first serial bit, or sticks after valid drops. Idle windows, where a request is active with an empty FIFO or a FIFO has data without a request, catch transfers started without both conditions.

// File: rtl/es_out_port.sv
module es_out_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          par_mode,
  input  logic          aud_req_n,
  input  logic          aud_avail,
  input  logic [DW-1:0] aud_byte,
  input  logic          aud_disc,
  output logic          aud_pop,
  input  logic          vid_req_n,
  input  logic          vid_avail,
  input  logic [DW-1:0] vid_byte,
  input  logic          vid_disc,
  output logic          vid_pop,
  output logic [DW-1:0] dout,
  output logic          dvalid,
  output logic          dstrm,
  output logic          derr_n
);
  localparam int CW = $clog2(DW);

  logic [CW-1:0] rem;
  logic [DW-2:0] shreg;
  logic          last_vid;

  wire free   = (rem == '0);
  wire a_ok   = aud_avail & ~aud_req_n;
  wire v_ok   = vid_avail & ~vid_req_n;
  wire pick_v = v_ok & (~a_ok | ~last_vid);
  wire grant  = free & (a_ok | v_ok);

  wire [DW-1:0] sel_byte = pick_v ? vid_byte : aud_byte;
  wire          sel_disc = pick_v ? vid_disc : aud_disc;

  assign aud_pop = grant & ~pick_v;
  assign vid_pop = grant & pick_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem      <= '0;
      shreg    <= '0;
      last_vid <= 1'b1;
      dout     <= '0;
      dvalid   <= 1'b0;
      dstrm    <= 1'b0;
      derr_n   <= 1'b1;
    end else if (grant) begin
      last_vid <= pick_v;
      dvalid   <= 1'b1;
      dstrm    <= pick_v;
      derr_n   <= ~sel_disc;
      if (par_mode) begin
        dout <= sel_byte;
        rem  <= '0;
      end else begin
        dout  <= {{(DW-1){1'b0}}, sel_byte[DW-1]};
        shreg <= sel_byte[DW-2:0];
        rem   <= CW'(DW-1);
      end
    end else if (!free) begin
      dout  <= {{(DW-1){1'b0}}, shreg[DW-2]};
      shreg <= shreg << 1;
      rem   <= rem - 1'b1;
    end else begin
      dvalid <= 1'b0;
      derr_n <= 1'b1;
    end
  end
endmodule

// File: rtl/es_out_port_sva.sv
module es_out_port_sva #(
  parameter int DW = 8,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          aud_req_n,
  input logic          aud_avail,
  input logic          aud_pop,
  input logic          vid_req_n,
  input logic          vid_avail,
  input logic          vid_pop,
  input logic [DW-1:0] dout,
  input logic          dvalid,
  input logic          dstrm,
  input logic          derr_n,
  input logic [CW-1:0] rem
);
  a_r1_idle_out_of_reset: assert property (@(posedge clk)
    !rst_n |=> (!dvalid && derr_n));

  a_r2_audio_pop_gated: assert property (@(posedge clk) disable iff (!rst_n)
    aud_pop |-> (!aud_req_n && aud_avail));

  a_r2_video_pop_gated: assert property (@(posedge clk) disable iff (!rst_n)
    vid_pop |-> (!vid_req_n && vid_avail));

  a_r6_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({aud_pop, vid_pop}));

  a_r3_pop_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (aud_pop || vid_pop) |=> dvalid);

  a_r4_serial_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (rem != '0) |-> (dout[DW-1:1] == '0));

  a_r5_no_grant_mid_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rem != '0) |-> !(aud_pop || vid_pop));

  a_r7_byte_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rem != '0) |=> (dvalid && $stable(dstrm) && $stable(derr_n)));

  a_r8_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !derr_n |-> dvalid);
endmodule

bind es_out_port es_out_port_sva #(.DW(DW), .CW(CW)) chk (
  .clk(clk), .rst_n(rst_n),
  .aud_req_n(aud_req_n), .aud_avail(aud_avail), .aud_pop(aud_pop),
  .vid_req_n(vid_req_n), .vid_avail(vid_avail), .vid_pop(vid_pop),
  .dout(dout), .dvalid(dvalid), .dstrm(dstrm), .derr_n(derr_n), .rem(rem)
);

// File: tb/es_out_port_test.sv
`timescale 1ns/1ps
module es_out_port_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, par_mode, aud_req_n, vid_req_n;
  logic       aud_avail, vid_avail, aud_disc, vid_disc, aud_pop, vid_pop;
  logic [7:0] aud_byte, vid_byte, dout;
  logic       dvalid, dstrm, derr_n;

  logic [7:0] a_mem [64];
  logic [7:0] v_mem [64];
  logic       a_dis [64];
  logic       v_dis [64];
  int ia = 0, iv = 0, lim_a = 0, lim_v = 0;

  assign aud_avail = (ia < lim_a);
  assign vid_avail = (iv < lim_v);
  assign aud_byte  = a_mem[ia[5:0]];
  assign vid_byte  = v_mem[iv[5:0]];
  assign aud_disc  = a_dis[ia[5:0]];
  assign vid_disc  = v_dis[iv[5:0]];

  es_out_port uut (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode),
    .aud_req_n(aud_req_n), .aud_avail(aud_avail), .aud_byte(aud_byte),
    .aud_disc(aud_disc), .aud_pop(aud_pop),
    .vid_req_n(vid_req_n), .vid_avail(vid_avail), .vid_byte(vid_byte),
    .vid_disc(vid_disc), .vid_pop(vid_pop),
    .dout(dout), .dvalid(dvalid), .dstrm(dstrm), .derr_n(derr_n)
  );

  typedef struct packed { logic p; logic s; logic e; logic [7:0] d; } item_t;
  item_t q[$];

  int checks = 0, fails = 0;
  int brem = 0;
  bit blastv = 1'b1;
  bit adv_a = 0, adv_v = 0;
  bit s_par = 1, s_ra = 1, s_rv = 1, s_rst = 0;
  int s_la = 0, s_lv = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic monitor();
    item_t it;
    if (q.size() == 0) begin
      chk(dvalid == 1'b0, "R2", "unexpected valid", dvalid, 0);
      chk(derr_n == 1'b1, "R8", "error while idle", derr_n, 1);
    end else begin
      it = q.pop_front();
      chk(dvalid == 1'b1, "R5", "valid gap in byte", dvalid, 1);
      if (it.p) chk(dout == it.d, "R3", "parallel data", dout, it.d);
      else      chk(dout == it.d, "R4", "serial bit", dout, it.d);
      chk(dstrm == it.s, "R7", "stream select", dstrm, it.s);
      chk(derr_n == ~it.e, "R8", "error flag", derr_n, ~it.e);
    end
  endtask

  task automatic step();
    bit ea, ev, both;
    int g;
    logic [7:0] b;
    logic e;
    @(negedge clk);
    if (adv_a) ia++;
    if (adv_v) iv++;
    adv_a = 0; adv_v = 0;
    rst_n = ~s_rst; par_mode = s_par; aud_req_n = s_ra; vid_req_n = s_rv;
    lim_a = s_la; lim_v = s_lv;
    if (!s_rst) monitor();
    #1;
    if (s_rst) return;
    ea = (ia < lim_a) && !aud_req_n;
    ev = (iv < lim_v) && !vid_req_n;
    both = ea && ev;
    g = 0;
    if (brem == 0) begin
      if (both) g = blastv ? 1 : 2;
      else if (ea) g = 1;
      else if (ev) g = 2;
    end
    if (both && brem == 0)
      chk({vid_pop, aud_pop} == 2'(g), "R6", "contested grant", {vid_pop, aud_pop}, g);
    else
      chk({vid_pop, aud_pop} == 2'(g), "R2", "grant", {vid_pop, aud_pop}, g);
    if (g != 0) begin
      blastv = (g == 2);
      b = (g == 2) ? v_mem[iv[5:0]] : a_mem[ia[5:0]];
      e = (g == 2) ? v_dis[iv[5:0]] : a_dis[ia[5:0]];
      if (g == 2) adv_v = 1; else adv_a = 1;
      if (par_mode) begin
        q.push_back({1'b1, (g == 2), e, b});
        brem = 0;
      end else begin
        for (int k = 7; k >= 0; k--) q.push_back({1'b0, (g == 2), e, 7'd0, b[k]});
        brem = 7;
      end
    end else if (brem > 0) brem--;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #600000;
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      a_mem[i] = 8'(i * 29 + 5);
      v_mem[i] = 8'(i * 53 + 163);
      a_dis[i] = (i == 3 || i == 9 || i == 17 || i == 40);
      v_dis[i] = (i == 5 || i == 12 || i == 30);
    end
    rst_n = 0; par_mode = 1; aud_req_n = 1; vid_req_n = 1;
    s_rst = 1;
    repeat (4) step();
    @(negedge clk);
    chk(dvalid == 1'b0, "R1", "valid in reset", dvalid, 0);
    chk(derr_n == 1'b1, "R1", "error in reset", derr_n, 1);
    chk(!aud_pop && !vid_pop, "R1", "pop in reset", {vid_pop, aud_pop}, 0);
    s_rst = 0;
    step();
    chk(dvalid == 1'b0, "R1", "valid after reset", dvalid, 0);
    chk(derr_n == 1'b1, "R1", "error after reset", derr_n, 1);

    // R3: parallel audio stream, including a flagged byte (R8)
    s_par = 1; s_ra = 0; s_la = 6;
    repeat (10) step();
    // R6 and R7: both streams contend in parallel mode
    s_rv = 0; s_la = 14; s_lv = 8;
    repeat (20) step();
    // R2: data present but no requests, then requests with empty FIFOs
    s_ra = 1; s_rv = 1; s_la = 30; s_lv = 20;
    repeat (6) step();
    s_ra = 0; s_rv = 0; s_la = ia; s_lv = iv;
    repeat (6) step();
    // R4 and R9: back-to-back serial audio bytes
    s_par = 0; s_ra = 0; s_rv = 1; s_la = ia + 3;
    repeat (30) step();
    // R5: request drops right after a serial byte starts
    s_la = ia + 2;
    while (brem == 0) step();
    s_ra = 1;
    repeat (5) step();
    s_ra = 0;
    repeat (20) step();
    // R5: mode flips to parallel during a serial byte
    s_rv = 0; s_lv = iv + 2;
    while (brem == 0) step();
    s_par = 1;
    repeat (10) step();
    s_par = 0;
    // R6 in serial mode with flagged video bytes (R8)
    s_ra = 0; s_rv = 0; s_la = ia + 6; s_lv = iv + 6;
    repeat (110) step();
    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      s_ra = ($urandom % 3 == 0);
      s_rv = ($urandom % 3 == 0);
      if ($urandom % 40 == 0) s_par = ~s_par;
      if (n % 60 == 0) begin
        s_la = (s_la + 2 > 64) ? 64 : s_la + 2;
        s_lv = (s_lv + 2 > 64) ? 64 : s_lv + 2;
      end
      step();
    end
    s_ra = 0; s_rv = 0;
    repeat (40) step();
    chk(q.size() == 0, "R5", "bytes left unsent", q.size(), 0);
    summary();
    $finish;
  end
endmodule